// File: doc/BRIEF.md
# Temperature Conversion Sequencer with Standby and One-Shot Control

This block decides when a multichannel temperature monitor converts and which channel it converts. In continuous operation it walks the sensing channels in a fixed rotation: it starts a conversion on the ADC, waits for the ADC to report completion, and then strobes the result into that channel's value register. The rotation runs without a gap beyond one idle cycle between conversions.

A configuration byte carries a standby bit. While standby is set the ADC is held off. If a conversion is running when standby takes effect, that conversion is aborted and its result is discarded. The bus side and the limit registers are not part of this block and keep working in standby. A one-shot strobe from the register interface, given while in standby, makes the block convert every channel once in rotation and then drop back to standby without software action.

The ADC result input works as a valid-only stream. `adc_done` marks a valid `adc_result`. There is no ready signal: the sequencer accepts a result in any cycle, and it ignores results that arrive with no conversion outstanding. The value-register side gets one write strobe per channel and is assumed always able to take the write, so no back-pressure exists anywhere in the path.

Top module: `tconv_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `adc_start`, `adc_abort` and `val_wr_en` are all zero and `adc_chan` is 0.
- R2: With standby clear, conversions are started by single-cycle `adc_start` pulses. Channels are converted in the order 0, 1, …, NUM_CH-1 and then 0 again. Channel 0 is the local sensor and the higher numbers are the remote sensors. `adc_chan` holds its value from the start pulse until the conversion ends.
- R3: When `adc_done` is high while a conversion is outstanding and may complete, `val_wr_en` in the next cycle has exactly bit `adc_chan` set, for one cycle, and `val_wr_data` equals the `adc_result` given with `adc_done`.
- R4: Standby is bit 6 of `cfg_byte`, where 1 means standby and 0 means continuous. While standby is set and no one-shot sequence is active, no `adc_start` is issued.
- R5: If standby takes effect while a conversion is outstanding, `adc_abort` pulses for one cycle in the next cycle and no value write happens for that conversion. This holds even when `adc_done` arrives in the same cycle.
- R6: A `oneshot_wr` pulse while in standby converts and writes channels 0 through NUM_CH-1 once each, in order. After that, no further `adc_start` is issued while standby stays set.
- R7: A `oneshot_wr` pulse in continuous mode, or during an active one-shot sequence, has no effect on starts, channels or writes.
- R8: When standby is cleared, the first conversion started is on channel 0.
- R9: `adc_done` with no conversion outstanding produces no value write.
- R10: Bits of `cfg_byte` other than bit 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_byte | input | 8 | Configuration byte; bit 6 = standby |
| oneshot_wr | input | 1 | One-cycle strobe from a one-shot register write |
| adc_start | output | 1 | One-cycle conversion start to the ADC |
| adc_abort | output | 1 | One-cycle pulse that cancels the running conversion |
| adc_chan | output | CH_W | Channel selected for the ADC |
| adc_done | input | 1 | Result valid from the ADC |
| adc_result | input | RES_W | Conversion result, qualified by `adc_done` |
| val_wr_en | output | NUM_CH | One-hot write strobe into the channel value registers |
| val_wr_data | output | RES_W | Data for the value-register write |

## Verification
A wrong channel pointer shows on `adc_chan` at the very next start pulse, and a write then lands on the wrong bit of `val_wr_en` a few cycles later. A stale outstanding-conversion flag shows within one cycle of a standby change: `adc_abort` is missing or spurious, a write slips through after standby, or a done pulse in an idle period gets committed. A stuck one-shot flag shows as extra starts after the third write of a one-shot sequence, or as starts that never come. The bench compares every output against a behavioural model on every cycle, so each of these is caught in the cycle it first appears.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int CFG_W    = 8;
  localparam int STBY_BIT = 6;

  typedef struct packed {
    logic start;
    logic abort;
    logic commit;
    logic clr;
    logic adv;
  } tcs_ctl_t;
endpackage

// File: rtl/tcs_ctrl.sv
module tcs_ctrl
  import tcs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     standby,
  input  logic     oneshot_wr,
  input  logic     adc_done,
  input  logic     ptr_last,
  output tcs_ctl_t ctl,
  output logic     busy,
  output logic     os_run
);
  logic hold;
  logic os_arm;

  always_comb begin
    hold       = standby & ~os_run;
    ctl.start  = ~busy & ~hold;
    ctl.abort  = busy & hold;
    ctl.commit = busy & ~hold & adc_done;
    ctl.clr    = hold;
    ctl.adv    = ctl.commit;
    os_arm     = oneshot_wr & standby & ~os_run;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      os_run <= 1'b0;
    end else begin
      if (ctl.start)
        busy <= 1'b1;
      else if (ctl.abort || ctl.commit)
        busy <= 1'b0;

      if (ctl.commit && ptr_last)
        os_run <= 1'b0;
      else if (os_arm)
        os_run <= 1'b1;
    end
  end
endmodule

// File: rtl/tcs_ptr.sv
module tcs_ptr #(
  parameter int NUM_CH = 3,
  parameter int CH_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  output logic [CH_W-1:0] ch,
  output logic            last
);
  localparam logic [CH_W-1:0] LAST_IDX = CH_W'(NUM_CH - 1);

  assign last = (ch == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n)
      ch <= '0;
    else if (clr)
      ch <= '0;
    else if (adv)
      ch <= last ? '0 : ch + 1'b1;
  end
endmodule

// File: rtl/tcs_commit.sv
module tcs_commit #(
  parameter int NUM_CH = 3,
  parameter int CH_W   = 2,
  parameter int RES_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [CH_W-1:0]   ch,
  input  logic [RES_W-1:0]  result,
  output logic [NUM_CH-1:0] wr_en,
  output logic [RES_W-1:0]  wr_data
);
  logic [NUM_CH-1:0] sel;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign sel[i] = commit && (ch == CH_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= sel;
      if (commit)
        wr_data <= result;
    end
  end
endmodule

// File: rtl/tconv_seq.sv
module tconv_seq
  import tcs_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int RES_W  = 11,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_byte,
  input  logic              oneshot_wr,
  output logic              adc_start,
  output logic              adc_abort,
  output logic [CH_W-1:0]   adc_chan,
  input  logic              adc_done,
  input  logic [RES_W-1:0]  adc_result,
  output logic [NUM_CH-1:0] val_wr_en,
  output logic [RES_W-1:0]  val_wr_data
);
  tcs_ctl_t        ctl;
  logic            busy;
  logic            os_run;
  logic            ptr_last;
  logic [CH_W-1:0] ch;
  logic            standby;
  logic            unused_cfg;

  assign standby    = cfg_byte[STBY_BIT];
  assign unused_cfg = ^{cfg_byte[CFG_W-1:STBY_BIT+1], cfg_byte[STBY_BIT-1:0]};

  tcs_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .standby    (standby),
    .oneshot_wr (oneshot_wr),
    .adc_done   (adc_done),
    .ptr_last   (ptr_last),
    .ctl        (ctl),
    .busy       (busy),
    .os_run     (os_run)
  );

  tcs_ptr #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctl.clr),
    .adv   (ctl.adv),
    .ch    (ch),
    .last  (ptr_last)
  );

  tcs_commit #(.NUM_CH(NUM_CH), .CH_W(CH_W), .RES_W(RES_W)) u_commit (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (ctl.commit),
    .ch      (ch),
    .result  (adc_result),
    .wr_en   (val_wr_en),
    .wr_data (val_wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adc_start <= 1'b0;
      adc_abort <= 1'b0;
    end else begin
      adc_start <= ctl.start;
      adc_abort <= ctl.abort;
    end
  end

  assign adc_chan = ch;
endmodule

// File: rtl/tcs_checker.sv
module tcs_checker #(
  parameter int NUM_CH = 3,
  parameter int CH_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby,
  input logic              os_run,
  input logic              adc_start,
  input logic              adc_abort,
  input logic [CH_W-1:0]   adc_chan,
  input logic [NUM_CH-1:0] val_wr_en
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start); // R2
  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> $stable(adc_chan)); // R2
  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(val_wr_en)); // R3
  AST_NO_START_IN_STBY: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !os_run) |=> !adc_start); // R4
  AST_ABORT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_abort |-> (val_wr_en == '0)); // R5
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_abort |=> !adc_abort); // R5
endmodule

bind tconv_seq tcs_checker #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .standby   (standby),
  .os_run    (os_run),
  .adc_start (adc_start),
  .adc_abort (adc_abort),
  .adc_chan  (adc_chan),
  .val_wr_en (val_wr_en)
);

// File: tb/tb_tconv_seq.sv
module tb_tconv_seq;
  localparam int PERIOD = 10;
  localparam int NCH    = 3;
  localparam int RW     = 11;
  localparam int CW     = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    cfg_byte = 8'h00;
  logic          oneshot_wr = 1'b0;
  logic          adc_start, adc_abort;
  logic [CW-1:0] adc_chan;
  logic          adc_done = 1'b0;
  logic [RW-1:0] adc_result = '0;
  logic [NCH-1:0] val_wr_en;
  logic [RW-1:0] val_wr_data;

  always #(PERIOD/2) clk = ~clk;

  tconv_seq #(.NUM_CH(NCH), .RES_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte), .oneshot_wr(oneshot_wr),
    .adc_start(adc_start), .adc_abort(adc_abort), .adc_chan(adc_chan),
    .adc_done(adc_done), .adc_result(adc_result),
    .val_wr_en(val_wr_en), .val_wr_data(val_wr_data)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done_flag = 0;

  // reference model state
  int m_busy = 0, m_ch = 0, m_os = 0;
  int e_start = 0, e_abort = 0, e_wr = 0, e_data = 0;

  // ADC model
  int lat = 3, cnt = 0, seq = 0;
  bit force_done = 0;

  // observation
  int wr_log[$];
  int n_start = 0, n_abort = 0;
  int first_chan_after = -1;
  bit watch_first = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int hold, commit, old_ch;
    if (!rst_n) begin
      m_busy = 0; m_ch = 0; m_os = 0;
      e_start = 0; e_abort = 0; e_wr = 0; e_data = 0;
    end else begin
      hold   = (cfg_byte[6] && !m_os) ? 1 : 0;
      commit = (m_busy && !hold && adc_done) ? 1 : 0;
      old_ch = m_ch;
      e_start = (!m_busy && !hold) ? 1 : 0;
      e_abort = (m_busy && hold) ? 1 : 0;
      e_wr    = commit ? (1 << m_ch) : 0;
      if (commit) e_data = int'(adc_result);
      if (hold) m_ch = 0;
      else if (commit) m_ch = (m_ch == NCH-1) ? 0 : m_ch + 1;
      if (commit && old_ch == NCH-1) m_os = 0;
      else if (oneshot_wr && cfg_byte[6] && !m_os) m_os = 1;
      if (e_start) m_busy = 1;
      else if (e_abort || commit) m_busy = 0;
    end
  end

  always @(negedge clk) begin
    if (!done_flag) begin
      chk(adc_start == e_start[0], "R2 adc_start", int'(adc_start), e_start);
      chk(adc_abort == e_abort[0], "R5 adc_abort", int'(adc_abort), e_abort);
      chk(int'(adc_chan) == m_ch, "R8 adc_chan", int'(adc_chan), m_ch);
      chk(int'(val_wr_en) == e_wr, "R3 val_wr_en", int'(val_wr_en), e_wr);
      if (e_wr != 0)
        chk(int'(val_wr_data) == e_data, "R3 val_wr_data", int'(val_wr_data), e_data);
    end
    for (int i = 0; i < NCH; i++) if (val_wr_en[i]) wr_log.push_back(i);
    if (adc_start) begin
      n_start++;
      if (watch_first) begin first_chan_after = int'(adc_chan); watch_first = 0; end
    end
    if (adc_abort) n_abort++;
    // ADC behaviour
    adc_done = 1'b0;
    if (force_done) begin
      adc_done = 1'b1; adc_result = RW'(700 + seq); seq++; force_done = 0;
    end else if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        adc_done = 1'b1; adc_result = RW'(int'(adc_chan) * 100 + seq); seq++;
      end
    end
    if (adc_start) cnt = lat;
    if (adc_abort) cnt = 0;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_os();
    @(negedge clk); oneshot_wr = 1'b1;
    @(negedge clk); oneshot_wr = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    cyc(3);
    // R1: outputs idle during reset
    chk(adc_start == 0 && adc_abort == 0 && val_wr_en == 0, "R1 reset outputs", int'(adc_start), 0);
    chk(adc_chan == 0, "R1 reset chan", int'(adc_chan), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: continuous rotation
    wr_log.delete();
    cyc(40);
    chk(wr_log.size() >= 6, "R2 write count", wr_log.size(), 6);
    for (int i = 0; i < 6 && i < wr_log.size(); i++)
      chk(wr_log[i] == i % NCH, "R2 rotation order", wr_log[i], i % NCH);

    // R7: one-shot in continuous ignored (model compares every cycle)
    pulse_os();
    cyc(10);

    // R10: other config bits have no effect
    @(negedge clk); cfg_byte = 8'hBF;
    cyc(15);
    @(negedge clk); cfg_byte = 8'h00;
    cyc(5);

    // R5 / R4: enter standby with a conversion in flight, done coincident
    @(negedge clk);
    while (!adc_start) @(negedge clk);
    @(negedge clk);
    n_abort = 0;
    cfg_byte = 8'h40;
    force_done = 1;
    wr_log.delete();
    n_start = 0;
    cyc(20);
    chk(n_abort == 1, "R5 abort pulses", n_abort, 1);
    chk(wr_log.size() == 0, "R5 no write after abort", wr_log.size(), 0);
    chk(n_start == 0, "R4 no start in standby", n_start, 0);

    // R9: stray done in standby
    @(negedge clk); force_done = 1;
    cyc(5);
    chk(wr_log.size() == 0, "R9 stray done ignored", wr_log.size(), 0);

    // R6 / R7: one-shot in standby, with a second pulse during it
    wr_log.delete(); n_start = 0;
    pulse_os();
    cyc(4);
    pulse_os();
    cyc(30);
    chk(wr_log.size() == NCH, "R6 one-shot write count", wr_log.size(), NCH);
    for (int i = 0; i < NCH && i < wr_log.size(); i++)
      chk(wr_log[i] == i, "R6 one-shot order", wr_log[i], i);
    chk(n_start == NCH, "R7 extra one-shot ignored", n_start, NCH);

    // R6 again with a different ADC latency
    lat = 1;
    wr_log.delete(); n_start = 0;
    pulse_os();
    cyc(20);
    chk(wr_log.size() == NCH, "R6 one-shot fast ADC", wr_log.size(), NCH);
    chk(n_start == NCH, "R6 returns to standby", n_start, NCH);

    // R8: leaving standby restarts at channel 0
    lat = 2;
    watch_first = 1;
    @(negedge clk); cfg_byte = 8'h00;
    cyc(10);
    chk(first_chan_after == 0, "R8 restart channel", first_chan_after, 0);

    // mid-rotation standby then resume
    cyc(7);
    @(negedge clk); cfg_byte = 8'h40;
    cyc(6);
    watch_first = 1;
    @(negedge clk); cfg_byte = 8'h00;
    cyc(20);
    chk(first_chan_after == 0, "R8 restart after mid-rotation stop", first_chan_after, 0);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule